// File: doc/BRIEF.md
# CAN Message Mailbox Controller

This block keeps eight message mailboxes between a host-side configuration port and an abstract frame engine that handles the bus itself. Each mailbox has a type, an identifier, an acceptance mask, a 4-bit transmit priority, a data length code, eight data bytes, a 16-bit timestamp and three flags: ready, aborted and ignored. Bit-level protocol work is not part of this block. The engine hands over each received frame as one pulse, and it takes transmit offers through a request/start/done handshake.

A received frame goes to the lowest-numbered mailbox that listens for that kind of frame and whose identifier matches under its mask. That mailbox's policy then decides what happens to the frame. For transmission, a tiny state machine picks one mailbox at a time. Its states are IDLE, OFFER and SEND.
- IDLE goes to OFFER when any mailbox is eligible to transmit. The mailbox with the lowest priority value wins.
- OFFER goes to SEND when the engine pulses `tx_start`.
- OFFER falls back to IDLE when, before the start, the offered mailbox is aborted, rewritten, re-commanded or stops being eligible.
- SEND goes to IDLE on `tx_done` (the frame was sent) or `tx_lost` (the frame failed and will be retried).

The host configures a mailbox with one write. It raises per-mailbox transfer and abort bits, and it reads status back through an index-selected read port.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, all ready, aborted and ignored flags are 0, and `tx_req` is 0.
- R2: A mailbox of type 0 (disabled) never receives a frame and is never offered for transmission, even after a transfer command.
- R3: Identifiers are 30 bits: bit 29 is the extended flag, bits 28:18 are the standard part and bits 17:0 are the extension. A frame matches a mailbox when the flags are equal and the masked XOR of the identifiers is zero. For a frame whose flag is 0, only bits 28:18 are compared.
- R4: A data frame goes to the lowest-index matching mailbox of type 1, 2 or 4 (type 4 only while it is waiting). A full type-1 mailbox (ready=1) discards the frame: its data and flags stay unchanged.
- R5: A type-2 mailbox that is already full takes the new frame in place of the old one and sets its ignored flag.
- R6: Among mailboxes eligible to transmit, the lowest priority value wins, and on a tie the lowest index wins. `tx_req` rises in the second cycle after the transfer command, and `tx_mbx` names the winner.
- R7: A transmit (type 3) mailbox sets ready on `tx_done`. On `tx_lost` it keeps its request and is offered again.
- R8: A transfer command clears that mailbox's ready, ignored and aborted flags.
- R9: A consumer (type 4) first sends a remote frame (`tx_rtr`=1) and sets no ready flag on completion. The next matching data frame fills it and sets ready.
- R10: A producer (type 5) with a transfer command is not offered until a matching remote frame arrives. It then sends its data frame (`tx_rtr`=0) and sets ready on `tx_done`.
- R11: An abort of a mailbox that is offered but not started drops `tx_req` in the next cycle, sets aborted, and nothing is sent.
- R12: An abort that arrives after `tx_start` waits for the frame to end. On `tx_done` the mailbox completes normally and aborted stays 0. On `tx_lost` it is cancelled: aborted is set and there is no retry.
- R13: An abort of a mailbox with nothing pending leaves its aborted flag at 0.
- R14: While `tx_req` stays high, `tx_mbx` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cfg_we | input | 1 | Write the full configuration of one mailbox |
| host_idx | input | 3 | Mailbox that is written |
| host_kind | input | 3 | Mailbox type (0..5) |
| host_prio | input | 4 | Transmit priority, lower wins |
| host_id | input | 30 | Identifier |
| host_mask | input | 30 | Acceptance mask |
| host_dlc | input | 4 | Length code to transmit |
| host_data | input | 64 | Data to transmit |
| host_xfer | input | 8 | Transfer command, one bit per mailbox |
| host_abort | input | 8 | Abort command, one bit per mailbox |
| rd_idx | input | 3 | Mailbox selected for read-back |
| rd_dlc | output | 4 | Stored length code |
| rd_rtr | output | 1 | Last received frame was a remote frame |
| rd_data | output | 64 | Stored data |
| rd_stamp | output | 16 | Timestamp of the last reception |
| mb_ready | output | 8 | Ready flags |
| mb_aborted | output | 8 | Aborted flags |
| mb_ignored | output | 8 | Ignored (overwritten) flags |
| rx_valid | input | 1 | One received frame is presented |
| rx_id | input | 30 | Received identifier |
| rx_rtr | input | 1 | Received frame is a remote frame |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data |
| rx_stamp | input | 16 | Reception timestamp |
| tx_req | output | 1 | A mailbox is offered for transmission |
| tx_mbx | output | 3 | Offered mailbox |
| tx_id | output | 30 | Offered identifier |
| tx_rtr | output | 1 | Offered frame is a remote frame |
| tx_dlc | output | 4 | Offered length code |
| tx_data | output | 64 | Offered data |
| tx_start | input | 1 | Engine commits the offered frame to the bus |
| tx_done | input | 1 | Committed frame was sent |
| tx_lost | input | 1 | Committed frame failed and must be retried |

## Verification
The assertions assume a well-behaved engine and host:
- The engine pulses `tx_start` only while `tx_req` is high.
- It raises `tx_done` or `tx_lost` only after a start, and never both at once.
- At most one frame arrives per pulse.
- The host never rewrites or re-commands a mailbox while its frame is on the bus.

The bench keeps within these assumptions by driving the engine side only through send tasks that wait for `tx_req`. It reconfigures mailboxes only while nothing is in SEND. Random identifiers and masks are drawn from a small pool, so matches, ties and full-mailbox collisions happen often.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [2:0] {
        MB_OFF    = 3'd0,
        MB_RX     = 3'd1,
        MB_RX_OVR = 3'd2,
        MB_TX     = 3'd3,
        MB_CONS   = 3'd4,
        MB_PROD   = 3'd5
    } mb_kind_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_SEND  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/mbx_match.sv
module mbx_match
    import mbx_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int STD_W  = 11,
    parameter int XT_W   = 18,
    localparam int ID_W  = STD_W + XT_W + 1,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [ID_W-1:0]              frame_id,
    input  logic                         frame_rtr,
    input  logic [NUM_MB-1:0][ID_W-1:0]  mb_id,
    input  logic [NUM_MB-1:0][ID_W-1:0]  mb_mask,
    input  logic [NUM_MB-1:0][2:0]       mb_kind,
    input  logic [NUM_MB-1:0]            mb_pend,
    input  logic [NUM_MB-1:0]            mb_armed,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [NUM_MB-1:0] cand;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        logic            listens;
        logic [ID_W-1:0] keep;
        logic [ID_W-1:0] diff;

        always_comb begin
            case (mb_kind[g])
                MB_RX, MB_RX_OVR: listens = !frame_rtr;
                MB_CONS:          listens = !frame_rtr && mb_armed[g];
                MB_PROD:          listens = frame_rtr && mb_pend[g];
                default:          listens = 1'b0;
            endcase
            // standard frames compare only the standard part
            keep = frame_id[ID_W-1] ? mb_mask[g]
                                    : {mb_mask[g][ID_W-1:XT_W], {XT_W{1'b0}}};
            diff = (frame_id ^ mb_id[g]) & keep;
            cand[g] = listens && (diff[ID_W-2:0] == '0)
                      && (frame_id[ID_W-1] == mb_id[g][ID_W-1]);
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = i[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mbx_tx_arb.sv
module mbx_tx_arb #(
    parameter int NUM_MB = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0]              elig,
    input  logic [NUM_MB-1:0][PRIO_W-1:0]  prio,
    output logic                           any,
    output logic [IDX_W-1:0]               win_idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        best    = '1;
        for (int i = 0; i < NUM_MB; i++) begin
            // strict compare keeps the lower index on a tie
            if (elig[i] && (!any || prio[i] < best)) begin
                any     = 1'b1;
                win_idx = i[IDX_W-1:0];
                best    = prio[i];
            end
        end
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int NUM_MB  = 8,
    parameter int PRIO_W  = 4,
    parameter int STD_W   = 11,
    parameter int XT_W    = 18,
    parameter int DLC_W   = 4,
    parameter int DATA_W  = 64,
    parameter int STAMP_W = 16,
    localparam int ID_W   = STD_W + XT_W + 1,
    localparam int IDX_W  = $clog2(NUM_MB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cfg_we,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic [2:0]         host_kind,
    input  logic [PRIO_W-1:0]  host_prio,
    input  logic [ID_W-1:0]    host_id,
    input  logic [ID_W-1:0]    host_mask,
    input  logic [DLC_W-1:0]   host_dlc,
    input  logic [DATA_W-1:0]  host_data,
    input  logic [NUM_MB-1:0]  host_xfer,
    input  logic [NUM_MB-1:0]  host_abort,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DLC_W-1:0]   rd_dlc,
    output logic               rd_rtr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [STAMP_W-1:0] rd_stamp,
    output logic [NUM_MB-1:0]  mb_ready,
    output logic [NUM_MB-1:0]  mb_aborted,
    output logic [NUM_MB-1:0]  mb_ignored,
    input  logic               rx_valid,
    input  logic [ID_W-1:0]    rx_id,
    input  logic               rx_rtr,
    input  logic [DLC_W-1:0]   rx_dlc,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic [STAMP_W-1:0] rx_stamp,
    output logic               tx_req,
    output logic [IDX_W-1:0]   tx_mbx,
    output logic [ID_W-1:0]    tx_id,
    output logic               tx_rtr,
    output logic [DLC_W-1:0]   tx_dlc,
    output logic [DATA_W-1:0]  tx_data,
    input  logic               tx_start,
    input  logic               tx_done,
    input  logic               tx_lost
);
    // mailbox storage
    logic [NUM_MB-1:0][2:0]         kind_q;
    logic [NUM_MB-1:0][PRIO_W-1:0]  prio_q;
    logic [NUM_MB-1:0][ID_W-1:0]    id_q;
    logic [NUM_MB-1:0][ID_W-1:0]    mask_q;
    logic [NUM_MB-1:0][DLC_W-1:0]   dlc_q;
    logic [NUM_MB-1:0][DATA_W-1:0]  data_q;
    logic [NUM_MB-1:0][STAMP_W-1:0] stamp_q;
    logic [NUM_MB-1:0]              rtr_q;
    logic [NUM_MB-1:0]              pend_q;
    logic [NUM_MB-1:0]              armed_q;   // consumer waiting / producer triggered
    logic [NUM_MB-1:0]              rdy_q;
    logic [NUM_MB-1:0]              abt_q;
    logic [NUM_MB-1:0]              ign_q;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] win_q;
    logic             defer_q;

    logic              rx_hit;
    logic [IDX_W-1:0]  rx_idx;
    logic [NUM_MB-1:0] tx_elig;
    logic              arb_any;
    logic [IDX_W-1:0]  arb_idx;
    logic              commit, finish_ok, finish_bad, drop_offer;

    mbx_match #(.NUM_MB(NUM_MB), .STD_W(STD_W), .XT_W(XT_W)) u_match (
        .frame_id (rx_id),
        .frame_rtr(rx_rtr),
        .mb_id    (id_q),
        .mb_mask  (mask_q),
        .mb_kind  (kind_q),
        .mb_pend  (pend_q),
        .mb_armed (armed_q),
        .hit      (rx_hit),
        .hit_idx  (rx_idx)
    );

    always_comb begin
        for (int i = 0; i < NUM_MB; i++) begin
            tx_elig[i] = pend_q[i] &&
                ((kind_q[i] == MB_TX) ||
                 (kind_q[i] == MB_CONS && !armed_q[i]) ||
                 (kind_q[i] == MB_PROD &&  armed_q[i]));
        end
    end

    mbx_tx_arb #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_arb (
        .elig   (tx_elig),
        .prio   (prio_q),
        .any    (arb_any),
        .win_idx(arb_idx)
    );

    assign commit     = (state_q == ARB_OFFER && tx_start) || state_q == ARB_SEND;
    assign finish_ok  = state_q == ARB_SEND && tx_done;
    assign finish_bad = state_q == ARB_SEND && tx_lost;
    assign drop_offer = !tx_elig[win_q] || host_abort[win_q] || host_xfer[win_q]
                        || (host_cfg_we && host_idx == win_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (arb_any) state_d = ARB_OFFER;
            ARB_OFFER: begin
                if (tx_start)        state_d = ARB_SEND;
                else if (drop_offer) state_d = ARB_IDLE;
            end
            ARB_SEND:  if (tx_done || tx_lost) state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            win_q   <= '0;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && arb_any) win_q <= arb_idx;
            if (state_d == ARB_IDLE)                    defer_q <= 1'b0;
            else if (commit && host_abort[win_q])       defer_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_req  = state_q == ARB_OFFER;
        tx_mbx  = win_q;
        tx_id   = id_q[win_q];
        tx_rtr  = kind_q[win_q] == MB_CONS;
        tx_dlc  = dlc_q[win_q];
        tx_data = data_q[win_q];
        rd_dlc   = dlc_q[rd_idx];
        rd_rtr   = rtr_q[rd_idx];
        rd_data  = data_q[rd_idx];
        rd_stamp = stamp_q[rd_idx];
        mb_ready   = rdy_q;
        mb_aborted = abt_q;
        mb_ignored = ign_q;
    end

    // mailbox updates: reception, completion, commands, configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0; prio_q <= '0; id_q <= '0; mask_q <= '0;
            dlc_q <= '0; data_q <= '0; stamp_q <= '0; rtr_q <= '0;
            pend_q <= '0; armed_q <= '0; rdy_q <= '0; abt_q <= '0; ign_q <= '0;
        end else begin
            if (rx_valid && rx_hit) begin
                case (kind_q[rx_idx])
                    MB_RX: if (!rdy_q[rx_idx]) begin
                        dlc_q[rx_idx] <= rx_dlc; data_q[rx_idx] <= rx_data;
                        stamp_q[rx_idx] <= rx_stamp; rtr_q[rx_idx] <= rx_rtr;
                        rdy_q[rx_idx] <= 1'b1;
                    end
                    MB_RX_OVR: begin
                        dlc_q[rx_idx] <= rx_dlc; data_q[rx_idx] <= rx_data;
                        stamp_q[rx_idx] <= rx_stamp; rtr_q[rx_idx] <= rx_rtr;
                        rdy_q[rx_idx] <= 1'b1;
                        if (rdy_q[rx_idx]) ign_q[rx_idx] <= 1'b1;
                    end
                    MB_CONS: begin
                        dlc_q[rx_idx] <= rx_dlc; data_q[rx_idx] <= rx_data;
                        stamp_q[rx_idx] <= rx_stamp; rtr_q[rx_idx] <= rx_rtr;
                        rdy_q[rx_idx] <= 1'b1; armed_q[rx_idx] <= 1'b0;
                    end
                    MB_PROD: begin
                        armed_q[rx_idx] <= 1'b1;
                        stamp_q[rx_idx] <= rx_stamp; rtr_q[rx_idx] <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (finish_ok) begin
                pend_q[win_q] <= 1'b0;
                case (kind_q[win_q])
                    MB_CONS: armed_q[win_q] <= 1'b1;
                    MB_PROD: begin armed_q[win_q] <= 1'b0; rdy_q[win_q] <= 1'b1; end
                    default: rdy_q[win_q] <= 1'b1;
                endcase
            end
            if (finish_bad && defer_q) begin
                pend_q[win_q] <= 1'b0; armed_q[win_q] <= 1'b0; abt_q[win_q] <= 1'b1;
            end
            for (int i = 0; i < NUM_MB; i++) begin
                if (host_abort[i] && !(commit && win_q == i[IDX_W-1:0])
                    && (pend_q[i] || armed_q[i])) begin
                    pend_q[i] <= 1'b0; armed_q[i] <= 1'b0; abt_q[i] <= 1'b1;
                end
                if (host_xfer[i]) begin
                    pend_q[i] <= 1'b1; armed_q[i] <= 1'b0;
                    rdy_q[i] <= 1'b0; ign_q[i] <= 1'b0; abt_q[i] <= 1'b0;
                end
            end
            if (host_cfg_we) begin
                kind_q[host_idx] <= host_kind;  prio_q[host_idx] <= host_prio;
                id_q[host_idx]   <= host_id;    mask_q[host_idx] <= host_mask;
                dlc_q[host_idx]  <= host_dlc;   data_q[host_idx] <= host_data;
                stamp_q[host_idx] <= '0;        rtr_q[host_idx]  <= 1'b0;
                pend_q[host_idx] <= 1'b0;       armed_q[host_idx] <= 1'b0;
                rdy_q[host_idx]  <= 1'b0;       abt_q[host_idx]  <= 1'b0;
                ign_q[host_idx]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tx_req,
    input logic [IDX_W-1:0]        tx_mbx,
    input logic                    tx_start,
    input logic                    tx_done,
    input logic                    tx_lost,
    input logic [NUM_MB-1:0]       host_abort,
    input arb_state_e              state_q,
    input logic [NUM_MB-1:0][2:0]  kind_q,
    input logic [NUM_MB-1:0]       rdy_q,
    input logic [NUM_MB-1:0]       ign_q
);
    // R14
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && $past(tx_req)) |-> $stable(tx_mbx));

    // R12
    start_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_start) |=> (state_q == ARB_SEND));

    // R11
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_start && host_abort[tx_mbx]) |=> !tx_req);

    // R7
    send_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SEND && (tx_done || tx_lost)) |=> (state_q == ARB_IDLE));

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        // R2
        off_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_q[g]) |-> ($past(kind_q[g]) != MB_OFF));
        // R5
        ign_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ign_q[g]) |-> ($past(kind_q[g]) == MB_RX_OVR));
    end
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .tx_mbx    (tx_mbx),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .tx_lost   (tx_lost),
    .host_abort(host_abort),
    .state_q   (state_q),
    .kind_q    (kind_q),
    .rdy_q     (rdy_q),
    .ign_q     (ign_q)
);

// File: tb/mbx_ctrl_tb.sv
module mbx_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cfg_we = 1'b0;
    logic [2:0]  host_idx = '0;
    logic [2:0]  host_kind = '0;
    logic [3:0]  host_prio = '0;
    logic [29:0] host_id = '0;
    logic [29:0] host_mask = '0;
    logic [3:0]  host_dlc = '0;
    logic [63:0] host_data = '0;
    logic [7:0]  host_xfer = '0;
    logic [7:0]  host_abort = '0;
    logic [2:0]  rd_idx = '0;
    logic [3:0]  rd_dlc;
    logic        rd_rtr;
    logic [63:0] rd_data;
    logic [15:0] rd_stamp;
    logic [7:0]  mb_ready, mb_aborted, mb_ignored;
    logic        rx_valid = 1'b0;
    logic [29:0] rx_id = '0;
    logic        rx_rtr = 1'b0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic [15:0] rx_stamp = '0;
    logic        tx_req;
    logic [2:0]  tx_mbx;
    logic [29:0] tx_id;
    logic        tx_rtr;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        tx_start = 1'b0, tx_done = 1'b0, tx_lost = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mbx_ctrl u_dut (.*);

    // bench model for random phases
    logic [29:0] m_id [8];
    logic [29:0] m_mask [8];
    logic [2:0]  m_kind [8];
    logic [3:0]  m_prio [8];
    logic [7:0]  e_rdy, e_ign;
    logic [63:0] e_data [8];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int idx, input logic [2:0] kind, input logic [3:0] prio,
                       input logic [29:0] id, input logic [29:0] mask, input logic [63:0] data);
        host_cfg_we = 1'b1; host_idx = 3'(idx); host_kind = kind; host_prio = prio;
        host_id = id; host_mask = mask; host_dlc = 4'd8; host_data = data;
        @(negedge clk);
        host_cfg_we = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] v);
        host_xfer = v; @(negedge clk); host_xfer = '0;
    endtask

    task automatic abrt(input logic [7:0] v);
        host_abort = v; @(negedge clk); host_abort = '0;
    endtask

    task automatic rx(input logic [29:0] id, input logic rtr, input logic [63:0] d);
        rx_valid = 1'b1; rx_id = id; rx_rtr = rtr; rx_dlc = 4'd8; rx_data = d;
        rx_stamp = rx_stamp + 16'd7;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 8 && !tx_req; k++) @(negedge clk);
    endtask

    task automatic start_only();
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic finish(input logic ok);
        tx_done = ok; tx_lost = !ok; @(negedge clk); tx_done = 1'b0; tx_lost = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) cfg(i, 3'd0, 4'd0, '0, '0, '0);
        cyc(3);
    endtask

    function automatic int ref_match(logic [29:0] fid, logic frtr);
        for (int i = 0; i < 8; i++) begin
            logic [29:0] keep;
            logic [29:0] d;
            keep = fid[29] ? m_mask[i] : {m_mask[i][29:18], 18'h0};
            d = (fid ^ m_id[i]) & keep & 30'h1fffffff;
            if ((m_kind[i] == 3'd1 || m_kind[i] == 3'd2) && !frtr
                && d == '0 && fid[29] == m_id[i][29])
                return i;
        end
        return -1;
    endfunction

    function automatic int ref_arb(logic [7:0] v);
        int best = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && m_kind[i] == 3'd3 && (best < 0 || m_prio[i] < m_prio[best]))
                best = i;
        return best;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 ready", 64'(mb_ready), 64'h0);
        chk("R1 aborted", 64'(mb_aborted), 64'h0);
        chk("R1 ignored", 64'(mb_ignored), 64'h0);
        chk("R1 tx_req", 64'(tx_req), 64'h0);

        // R3 standard frame ignores the extension bits, flag must match
        cfg(0, 3'd1, 4'd0, {1'b0, 11'h123, 18'h0}, 30'h3fffffff, '0);
        rx({1'b0, 11'h123, 18'h3ffff}, 1'b0, 64'hA1);
        chk("R3 std match", 64'(mb_ready[0]), 64'h1);
        xfer(8'h01);
        chk("R8 ready cleared", 64'(mb_ready[0]), 64'h0);
        rx({1'b1, 11'h123, 18'h0}, 1'b0, 64'hA2);
        chk("R3 flag mismatch", 64'(mb_ready[0]), 64'h0);

        // R2 disabled mailbox
        cfg(0, 3'd0, 4'd0, {1'b0, 11'h123, 18'h0}, 30'h3fffffff, '0);
        rx({1'b0, 11'h123, 18'h0}, 1'b0, 64'hA3);
        chk("R2 no receive", 64'(mb_ready[0]), 64'h0);
        xfer(8'h01);
        cyc(3);
        chk("R2 no offer", 64'(tx_req), 64'h0);

        // R7 transmit, lost then retried, then done
        cfg(1, 3'd3, 4'd2, {1'b0, 11'h055, 18'h0}, '0, 64'hDEAD_BEEF_0000_1111);
        xfer(8'h02);
        cyc(1);
        chk("R6 req after command", 64'(tx_req), 64'h1);
        chk("R6 tx_mbx", 64'(tx_mbx), 64'd1);
        chk("R7 tx_data", tx_data, 64'hDEAD_BEEF_0000_1111);
        start_only();
        finish(1'b0);
        wait_req();
        chk("R7 retry after lost", 64'(tx_req), 64'h1);
        chk("R7 lost no ready", 64'(mb_ready[1]), 64'h0);
        start_only();
        finish(1'b1);
        chk("R7 ready on done", 64'(mb_ready[1]), 64'h1);
        xfer(8'h02);
        chk("R8 xfer clears ready", 64'(mb_ready[1]), 64'h0);
        wait_req();
        start_only();
        finish(1'b1);

        // R9 consumer
        cfg(2, 3'd4, 4'd1, {1'b0, 11'h2aa, 18'h0}, 30'h3fffffff, '0);
        xfer(8'h04);
        wait_req();
        chk("R9 consumer mbx", 64'(tx_mbx), 64'd2);
        chk("R9 remote frame", 64'(tx_rtr), 64'h1);
        start_only();
        finish(1'b1);
        chk("R9 no ready after remote", 64'(mb_ready[2]), 64'h0);
        rx({1'b0, 11'h2aa, 18'h0}, 1'b0, 64'h1122_3344_5566_7788);
        rd_idx = 3'd2; #1;
        chk("R9 reply ready", 64'(mb_ready[2]), 64'h1);
        chk("R9 reply data", rd_data, 64'h1122_3344_5566_7788);

        // R10 producer
        cfg(3, 3'd5, 4'd1, {1'b0, 11'h3c3, 18'h0}, 30'h3fffffff, 64'hCAFE);
        xfer(8'h08);
        cyc(3);
        chk("R10 waits for remote", 64'(tx_req), 64'h0);
        rx({1'b0, 11'h3c3, 18'h0}, 1'b1, 64'h0);
        wait_req();
        chk("R10 offered", 64'(tx_req), 64'h1);
        chk("R10 mbx", 64'(tx_mbx), 64'd3);
        chk("R10 data frame", 64'(tx_rtr), 64'h0);
        chk("R10 payload", tx_data, 64'hCAFE);
        start_only();
        finish(1'b1);
        chk("R10 ready", 64'(mb_ready[3]), 64'h1);

        // R11 abort before start
        cfg(4, 3'd3, 4'd0, {1'b0, 11'h011, 18'h0}, '0, 64'h44);
        xfer(8'h10);
        wait_req();
        chk("R11 offered", 64'(tx_mbx), 64'd4);
        abrt(8'h10);
        chk("R11 req dropped", 64'(tx_req), 64'h0);
        chk("R11 aborted", 64'(mb_aborted[4]), 64'h1);
        cyc(3);
        chk("R11 not resent", 64'(tx_req), 64'h0);

        // R12 abort after start
        cfg(5, 3'd3, 4'd0, {1'b0, 11'h012, 18'h0}, '0, 64'h55);
        xfer(8'h20);
        wait_req();
        start_only();
        abrt(8'h20);
        chk("R12 deferred", 64'(mb_aborted[5]), 64'h0);
        finish(1'b1);
        chk("R12 done ready", 64'(mb_ready[5]), 64'h1);
        chk("R12 done no abort", 64'(mb_aborted[5]), 64'h0);
        xfer(8'h20);
        wait_req();
        start_only();
        abrt(8'h20);
        finish(1'b0);
        chk("R12 lost aborted", 64'(mb_aborted[5]), 64'h1);
        cyc(3);
        chk("R12 no retry", 64'(tx_req), 64'h0);

        // R13 abort with nothing pending
        cfg(6, 3'd3, 4'd0, {1'b0, 11'h013, 18'h0}, '0, 64'h66);
        abrt(8'h40);
        chk("R13 no abort flag", 64'(mb_aborted[6]), 64'h0);

        // random reception against the model (R3 R4 R5 R8)
        clear_all();
        for (int i = 0; i < 8; i++) begin
            m_kind[i] = 3'($urandom % 3);
            m_id[i]   = {($urandom % 4 == 0), 11'($urandom % 8), 18'($urandom % 4)};
            m_mask[i] = {1'b0, 11'h7f8 | 11'($urandom % 8), 16'hffff, 2'($urandom)};
            e_data[i] = '0;
            cfg(i, m_kind[i], 4'd0, m_id[i], m_mask[i], '0);
        end
        e_rdy = '0; e_ign = '0;
        for (int f = 0; f < 60; f++) begin
            logic [29:0] fid;
            logic [63:0] d;
            int hit;
            fid = {($urandom % 4 == 0), 11'($urandom % 8), 18'($urandom % 4)};
            d = {$urandom, $urandom};
            hit = ref_match(fid, 1'b0);
            if (hit >= 0) begin
                if (m_kind[hit] == 3'd1) begin
                    if (!e_rdy[hit]) begin e_data[hit] = d; e_rdy[hit] = 1'b1; end
                end else begin
                    if (e_rdy[hit]) e_ign[hit] = 1'b1;
                    e_data[hit] = d; e_rdy[hit] = 1'b1;
                end
            end
            rx(fid, 1'b0, d);
            chk("R4 ready vector", 64'(mb_ready), 64'(e_rdy));
            chk("R5 ignored vector", 64'(mb_ignored), 64'(e_ign));
            if (hit >= 0) begin
                rd_idx = 3'(hit); #1;
                chk("R4 stored data", rd_data, e_data[hit]);
            end
            if (f % 5 == 4) begin
                logic [7:0] v;
                v = 8'($urandom);
                xfer(v);
                e_rdy = e_rdy & ~v; e_ign = e_ign & ~v;
                chk("R8 ready after xfer", 64'(mb_ready), 64'(e_rdy));
            end
        end

        // random arbitration (R6 R7)
        for (int it = 0; it < 20; it++) begin
            logic [7:0] v;
            int w;
            clear_all();
            for (int i = 0; i < 8; i++) begin
                m_kind[i] = ($urandom % 4 == 0) ? 3'd0 : 3'd3;
                m_prio[i] = 4'($urandom % 4);
                cfg(i, m_kind[i], m_prio[i], 30'(i), '0, 64'(i));
            end
            cyc(2);
            v = 8'($urandom);
            w = ref_arb(v);
            xfer(v);
            cyc(1);
            if (w < 0) chk("R6 nothing offered", 64'(tx_req), 64'h0);
            else begin
                chk("R6 offered", 64'(tx_req), 64'h1);
                chk("R6 winner", 64'(tx_mbx), 64'(w));
                if (it % 2 == 0) begin
                    start_only();
                    finish(1'b1);
                    chk("R7 winner ready", 64'(mb_ready[w]), 64'h1);
                end
            end
        end
        clear_all();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule